// File: doc/BRIEF.md
# Position Compare and Event Unit

This block watches the phase count and the revolution count of a position decoder. It raises a compare event when both counts reach their programmed reference values, and it can restrict that event to one direction of rotation. The revolution count can be left out of the match. The block collects four event sources into one sticky status word: the compare event, a watchdog timeout pulse, a home input pulse and an index (Z) input pulse. Software clears status bits by writing ones to them.

Four enable masks send the events to four places. The interrupt and DMA request outputs are levels taken from the sticky status bits. The trigger output and the capture strobe are one-cycle pulses taken from newly arriving events. The capture strobe tells the surrounding logic to copy the live counters into their read registers. All masks and the clear word use the status word's 32-bit layout. The counters themselves and the register bus are outside this block.

Top module: `poscmp_event_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the status word is zero, and irq, dma_req, trig_out and load_strobe are low.
- R2: The status word keeps the watchdog event at bit 31, the home event at bit 30, the compare event at bit 29 and the index event at bit 28. An event pulse sampled at a clock edge sets its bit from that edge onward. Bits 27 to 0 always read 0.
- R3: A clear write (clr_we high) clears every status bit whose clr_data bit is 1. Status bits whose clr_data bit is 0 keep their value. With no clear write and no event, the status word does not change.
- R4: If an event arrives at the same edge as a clear write of its own bit, the bit is set after that edge.
- R5: A compare match requires ph_count to equal ph_ref. It also requires z_count to equal z_ref, unless z_ignore is 1, in which case z_count is not compared.
- R6: When dir_any is 0, a match also requires dir_neg to equal dir_want. A dir_want of 0 accepts only positive rotation (dir_neg=0), and a dir_want of 1 accepts only negative rotation (dir_neg=1). When dir_any is 1, both directions are accepted.
- R7: The compare event fires only at the first edge where the match condition is true after being false. If the condition holds for several cycles, the event fires once, and a status bit cleared while the condition still holds stays clear.
- R8: irq is high when any status bit 31..28 is set together with its bit in irq_mask. dma_req follows the same rule using dma_mask.
- R9: trig_out is high for exactly the one cycle after an edge at which an event arrived whose bit in trig_mask is set. Otherwise it is low.
- R10: load_strobe follows the rule of R9 using load_mask. It requests a copy of the counters into the read registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_count | input | PH_W | Live phase count |
| z_count | input | Z_W | Live revolution count |
| dir_neg | input | 1 | Present rotation direction, 1 = negative |
| ph_ref | input | PH_W | Phase compare value |
| z_ref | input | Z_W | Revolution compare value |
| z_ignore | input | 1 | 1 = leave the revolution count out of the match |
| dir_want | input | 1 | Required direction, 0 = positive, 1 = negative |
| dir_any | input | 1 | 1 = accept either direction |
| wdog_pulse | input | 1 | Watchdog timeout event |
| home_pulse | input | 1 | Home input event |
| zidx_pulse | input | 1 | Index input event |
| clr_we | input | 1 | Clear-write strobe for the status word |
| clr_data | input | 32 | Write-one-to-clear data |
| irq_mask | input | 32 | Interrupt enables, status layout |
| dma_mask | input | 32 | DMA request enables, status layout |
| trig_mask | input | 32 | Trigger output enables, status layout |
| load_mask | input | 32 | Capture strobe enables, status layout |
| status_word | output | 32 | Sticky event status |
| irq | output | 1 | Interrupt level |
| dma_req | output | 1 | DMA request level |
| trig_out | output | 1 | Trigger pulse |
| load_strobe | output | 1 | Counter capture pulse |

## Verification
The assertions assume that the event pulses, the clear strobe and all configuration inputs change only between clock edges and are stable at each edge. They also assume that the counts are simple binary values, so that an equality test is the whole match. The bench drives every input on the falling edge and holds it through the next rising edge. Its random stretch keeps the counts within a few values of the references, so that matches, held matches and released matches all occur often.

// File: rtl/poscmp_pkg.sv
package poscmp_pkg;
  localparam int REG_W  = 32;
  localparam int EV_N   = 4;
  localparam int EV_LSB = REG_W - EV_N;
  // order within the event field (bit 0 = lowest status bit of the field)
  localparam int EV_ZIDX = 0;
  localparam int EV_CMP  = 1;
  localparam int EV_HOME = 2;
  localparam int EV_WDOG = 3;
  localparam int N_ROUTE = 4;
  // route indices: levels first, then pulses
  localparam int RT_IRQ  = 0;
  localparam int RT_DMA  = 1;
  localparam int RT_TRIG = 2;
  localparam int RT_LOAD = 3;
  localparam int N_LEVEL = 2;

  function automatic logic [EV_N-1:0] field_of(input logic [REG_W-1:0] w);
    return w[REG_W-1:EV_LSB];
  endfunction

  function automatic logic [REG_W-1:0] word_of(input logic [EV_N-1:0] f);
    return {f, {EV_LSB{1'b0}}};
  endfunction

  function automatic logic [EV_N-1:0] w1c_next(input logic [EV_N-1:0] cur,
                                               input logic [EV_N-1:0] clr,
                                               input logic [EV_N-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/pos_matcher.sv
module pos_matcher #(
  parameter int PH_W = 16,
  parameter int Z_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_count,
  input  logic [Z_W-1:0]  z_count,
  input  logic            dir_neg,
  input  logic [PH_W-1:0] ph_ref,
  input  logic [Z_W-1:0]  z_ref,
  input  logic            z_ignore,
  input  logic            dir_want,
  input  logic            dir_any,
  output logic            match_now,
  output logic            match_hit
);
  logic armed_q;

  function automatic logic dir_ok(input logic neg, input logic want, input logic any);
    return any | (neg == want);
  endfunction

  assign match_now = (ph_count == ph_ref) && (z_ignore || (z_count == z_ref))
                     && dir_ok(dir_neg, dir_want, dir_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= match_now;
  end

  assign match_hit = match_now & ~armed_q;
endmodule

// File: rtl/event_status.sv
module event_status
  import poscmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev,
  input  logic            clr_we,
  input  logic [EV_N-1:0] clr_bits,
  output logic [EV_N-1:0] st
);
  logic [EV_N-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= w1c_next(st, clr_eff, ev);
  end
endmodule

// File: rtl/event_router.sv
module event_router
  import poscmp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [EV_N-1:0]               st,
  input  logic [EV_N-1:0]               ev,
  input  logic [N_ROUTE-1:0][EV_N-1:0]  masks,
  output logic [N_ROUTE-1:0]            outs
);
  for (genvar r = 0; r < N_ROUTE; r++) begin : g_route
    if (r < N_LEVEL) begin : g_level
      assign outs[r] = |(st & masks[r]);
    end else begin : g_pulse
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= |(ev & masks[r]);
      end
      assign outs[r] = q;
    end
  end
endmodule

// File: rtl/poscmp_event_unit.sv
module poscmp_event_unit
  import poscmp_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int Z_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph_count,
  input  logic [Z_W-1:0]   z_count,
  input  logic             dir_neg,
  input  logic [PH_W-1:0]  ph_ref,
  input  logic [Z_W-1:0]   z_ref,
  input  logic             z_ignore,
  input  logic             dir_want,
  input  logic             dir_any,
  input  logic             wdog_pulse,
  input  logic             home_pulse,
  input  logic             zidx_pulse,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_data,
  input  logic [REG_W-1:0] irq_mask,
  input  logic [REG_W-1:0] dma_mask,
  input  logic [REG_W-1:0] trig_mask,
  input  logic [REG_W-1:0] load_mask,
  output logic [REG_W-1:0] status_word,
  output logic             irq,
  output logic             dma_req,
  output logic             trig_out,
  output logic             load_strobe
);
  logic                         match_now;
  logic                         match_hit;
  logic [EV_N-1:0]              ev_field;
  logic [EV_N-1:0]              st_field;
  logic [N_ROUTE-1:0][EV_N-1:0] route_masks;
  logic [N_ROUTE-1:0]           route_out;
  logic                         unused_low;

  assign unused_low = ^{clr_data[EV_LSB-1:0], irq_mask[EV_LSB-1:0], dma_mask[EV_LSB-1:0],
                        trig_mask[EV_LSB-1:0], load_mask[EV_LSB-1:0]};

  pos_matcher #(.PH_W(PH_W), .Z_W(Z_W)) u_match (
    .clk(clk), .rst_n(rst_n), .ph_count(ph_count), .z_count(z_count), .dir_neg(dir_neg),
    .ph_ref(ph_ref), .z_ref(z_ref), .z_ignore(z_ignore), .dir_want(dir_want),
    .dir_any(dir_any), .match_now(match_now), .match_hit(match_hit)
  );

  always_comb begin
    ev_field          = '0;
    ev_field[EV_WDOG] = wdog_pulse;
    ev_field[EV_HOME] = home_pulse;
    ev_field[EV_CMP]  = match_hit;
    ev_field[EV_ZIDX] = zidx_pulse;
  end

  event_status u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev_field), .clr_we(clr_we),
    .clr_bits(field_of(clr_data)), .st(st_field)
  );

  always_comb begin
    route_masks          = '0;
    route_masks[RT_IRQ]  = field_of(irq_mask);
    route_masks[RT_DMA]  = field_of(dma_mask);
    route_masks[RT_TRIG] = field_of(trig_mask);
    route_masks[RT_LOAD] = field_of(load_mask);
  end

  event_router u_route (
    .clk(clk), .rst_n(rst_n), .st(st_field), .ev(ev_field),
    .masks(route_masks), .outs(route_out)
  );

  assign status_word = word_of(st_field);
  assign irq         = route_out[RT_IRQ];
  assign dma_req     = route_out[RT_DMA];
  assign trig_out    = route_out[RT_TRIG];
  assign load_strobe = route_out[RT_LOAD];
endmodule

// File: rtl/poscmp_event_chk.sv
module poscmp_event_chk #(
  parameter int PH_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     status_word,
  input logic [3:0]      ev_field,
  input logic            match_hit,
  input logic [PH_W-1:0] ph_count,
  input logic [PH_W-1:0] ph_ref,
  input logic            clr_we,
  input logic [31:0]     clr_data,
  input logic [31:0]     trig_mask,
  input logic            irq,
  input logic            trig_out,
  input logic            load_strobe
);
  assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[27:0] == 28'd0);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && ev_field == 4'd0) |=> $stable(status_word));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ev_field == 4'd0) |=> ((status_word[31:28] & $past(clr_data[31:28])) == 4'd0));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_field != 4'd0) |=> ((status_word[31:28] & $past(ev_field)) == $past(ev_field)));

  assert_hit_needs_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> (ph_count == ph_ref));

  assert_hit_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> !match_hit);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_word != 32'd0));

  assert_trig_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_field & trig_mask[31:28]) == 4'd0) |=> !trig_out);

  assert_load_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_field == 4'd0) |=> !load_strobe);
endmodule

bind poscmp_event_unit poscmp_event_chk #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_word(status_word), .ev_field(ev_field),
  .match_hit(match_hit), .ph_count(ph_count), .ph_ref(ph_ref), .clr_we(clr_we),
  .clr_data(clr_data), .trig_mask(trig_mask), .irq(irq), .trig_out(trig_out),
  .load_strobe(load_strobe)
);

// File: tb/tb_poscmp_event_unit.sv
module tb_poscmp_event_unit;
  localparam int PH_W = 16;
  localparam int Z_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PH_W-1:0] ph_count = '0, ph_ref = 16'd40;
  logic [Z_W-1:0]  z_count = '0, z_ref = 16'd3;
  logic dir_neg = 0, z_ignore = 0, dir_want = 0, dir_any = 0;
  logic wdog_pulse = 0, home_pulse = 0, zidx_pulse = 0, clr_we = 0;
  logic [31:0] clr_data = '0, irq_mask = '0, dma_mask = '0, trig_mask = '0, load_mask = '0;
  logic [31:0] status_word;
  logic irq, dma_req, trig_out, load_strobe;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // reference state, events held as separate bits
  bit m_w, m_h, m_c, m_z;
  bit m_prev_match, m_trig, m_load;

  always #5 clk = ~clk;

  poscmp_event_unit #(.PH_W(PH_W), .Z_W(Z_W)) dut (
    .clk(clk), .rst_n(rst_n), .ph_count(ph_count), .z_count(z_count), .dir_neg(dir_neg),
    .ph_ref(ph_ref), .z_ref(z_ref), .z_ignore(z_ignore), .dir_want(dir_want),
    .dir_any(dir_any), .wdog_pulse(wdog_pulse), .home_pulse(home_pulse),
    .zidx_pulse(zidx_pulse), .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
    .dma_mask(dma_mask), .trig_mask(trig_mask), .load_mask(load_mask),
    .status_word(status_word), .irq(irq), .dma_req(dma_req), .trig_out(trig_out),
    .load_strobe(load_strobe)
  );

  function automatic bit model_match();
    bit ok;
    ok = (ph_count == ph_ref);
    if (!z_ignore && z_count != z_ref) ok = 0;
    if (!dir_any) begin
      if (dir_want == 1'b0 && dir_neg) ok = 0;
      if (dir_want == 1'b1 && !dir_neg) ok = 0;
    end
    return ok;
  endfunction

  task automatic model_edge();
    bit mt, e_w, e_h, e_c, e_z;
    if (!rst_n) begin
      {m_w, m_h, m_c, m_z, m_prev_match, m_trig, m_load} = '0;
      return;
    end
    mt = model_match();
    e_w = wdog_pulse; e_h = home_pulse; e_z = zidx_pulse;
    e_c = mt && !m_prev_match;
    m_prev_match = mt;
    m_trig = (e_w && trig_mask[31]) || (e_h && trig_mask[30]) ||
             (e_c && trig_mask[29]) || (e_z && trig_mask[28]);
    m_load = (e_w && load_mask[31]) || (e_h && load_mask[30]) ||
             (e_c && load_mask[29]) || (e_z && load_mask[28]);
    if (clr_we) begin
      if (clr_data[31]) m_w = 0;
      if (clr_data[30]) m_h = 0;
      if (clr_data[29]) m_c = 0;
      if (clr_data[28]) m_z = 0;
    end
    if (e_w) m_w = 1;
    if (e_h) m_h = 1;
    if (e_c) m_c = 1;
    if (e_z) m_z = 1;
  endtask

  task automatic compare();
    logic [31:0] exp_st;
    bit exp_irq, exp_dma;
    exp_st = 32'd0;
    exp_st[31] = m_w; exp_st[30] = m_h; exp_st[29] = m_c; exp_st[28] = m_z;
    exp_irq = (m_w && irq_mask[31]) || (m_h && irq_mask[30]) ||
              (m_c && irq_mask[29]) || (m_z && irq_mask[28]);
    exp_dma = (m_w && dma_mask[31]) || (m_h && dma_mask[30]) ||
              (m_c && dma_mask[29]) || (m_z && dma_mask[28]);
    vectors++;
    if (status_word !== exp_st || irq !== exp_irq || dma_req !== exp_dma ||
        trig_out !== m_trig || load_strobe !== m_load) begin
      miscompares++;
      $display("FAIL %s t=%0t actual st=%h irq=%b dma=%b trig=%b load=%b expected st=%h irq=%b dma=%b trig=%b load=%b",
               cur_req, $time, status_word, irq, dma_req, trig_out, load_strobe,
               exp_st, exp_irq, exp_dma, m_trig, m_load);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic drop_pulses();
    wdog_pulse = 0; home_pulse = 0; zidx_pulse = 0; clr_we = 0; clr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R2: each event sets its own bit (31 wdog, 30 home, 28 index)
    cur_req = "R2";
    wdog_pulse = 1; tick(); drop_pulses(); tick();
    home_pulse = 1; tick(); drop_pulses(); tick();
    zidx_pulse = 1; tick(); drop_pulses(); tick();

    // R3: partial clear, zero clear, full clear
    cur_req = "R3";
    clr_we = 1; clr_data = 32'h4000_0000; tick(); drop_pulses(); tick();
    clr_we = 1; clr_data = 32'h0000_0000; tick(); drop_pulses(); tick();
    clr_we = 1; clr_data = 32'h0FFF_FFFF; tick(); drop_pulses(); tick();
    clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses(); tick();

    // R4: event and clear of the same bit together
    cur_req = "R4";
    zidx_pulse = 1; clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses(); tick();
    clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses();

    // R5: phase equal, revolution differs, then ignored
    cur_req = "R5";
    ph_count = ph_ref; z_count = 16'd9; tick(); tick();
    z_ignore = 1; tick(); tick();
    z_ignore = 0; ph_count = 16'd0; tick();
    z_count = z_ref; ph_count = ph_ref; tick(); ph_count = 16'd1; tick();
    clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses();

    // R6: direction qualification
    cur_req = "R6";
    dir_want = 0; dir_neg = 1; ph_count = ph_ref; tick(); ph_count = 0; tick();
    dir_want = 1; dir_neg = 1; ph_count = ph_ref; tick(); ph_count = 0; tick();
    clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses();
    dir_want = 1; dir_neg = 0; ph_count = ph_ref; tick(); ph_count = 0; tick();
    dir_any = 1; ph_count = ph_ref; tick(); ph_count = 0; tick();
    dir_any = 0; dir_want = 0;

    // R7: held match fires once; cleared bit stays clear while held
    cur_req = "R7";
    clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses();
    ph_count = ph_ref; tick(); tick(); tick();
    clr_we = 1; clr_data = 32'h2000_0000; tick(); drop_pulses();
    tick(); tick();
    ph_count = 0; tick();

    // R8: interrupt and DMA masks
    cur_req = "R8";
    irq_mask = 32'h8000_0000; dma_mask = 32'h1000_0000; tick();
    home_pulse = 1; tick(); drop_pulses(); tick();
    irq_mask = 32'h4000_0000; tick();
    zidx_pulse = 1; tick(); drop_pulses(); tick();
    clr_we = 1; clr_data = 32'hF000_0000; tick(); drop_pulses(); tick();

    // R9: trigger pulse
    cur_req = "R9";
    trig_mask = 32'h2000_0000;
    home_pulse = 1; tick(); drop_pulses(); tick();
    ph_count = ph_ref; tick(); tick(); tick(); ph_count = 0; tick();

    // R10: capture strobe
    cur_req = "R10";
    load_mask = 32'h8000_0000;
    wdog_pulse = 1; tick(); wdog_pulse = 1; tick(); drop_pulses(); tick();
    zidx_pulse = 1; tick(); drop_pulses(); tick();

    // mixed random traffic near the references
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      ph_count   = ph_ref + 16'($urandom_range(0, 2)) - 16'd1;
      z_count    = z_ref + 16'($urandom_range(0, 1));
      dir_neg    = 1'($urandom_range(0, 1));
      z_ignore   = ($urandom_range(0, 3) == 0);
      dir_any    = ($urandom_range(0, 3) == 0);
      dir_want   = 1'($urandom_range(0, 1));
      wdog_pulse = ($urandom_range(0, 7) == 0);
      home_pulse = ($urandom_range(0, 7) == 0);
      zidx_pulse = ($urandom_range(0, 5) == 0);
      clr_we     = ($urandom_range(0, 3) == 0);
      clr_data   = $urandom;
      irq_mask   = $urandom;
      dma_mask   = $urandom;
      trig_mask  = $urandom;
      load_mask  = $urandom;
      tick();
    end
    drop_pulses();
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule